// File: doc/BRIEF.md
# Dropped-Frame Event Counter with Midpoint Interrupt

This block keeps a running tally of receive frames that the datapath had to discard. Each discard arrives as a single-cycle pulse, and each pulse adds one to a 32-bit count. The host reads the tally through a small register window. Reading the tally returns its value and sets it back to zero in the same access, so each read reports the discards since the previous read.

The block raises an interrupt when the tally passes through the middle of its range, which is the step from 0x7FFFFFFF to 0x80000000. The host therefore gets notice long before the count could wrap. The crossing sets a sticky status flag. The host clears the flag by writing a one to it. The interrupt line is the flag gated by an enable bit that the host controls.

The register window has three offsets. The tally sits at byte offset 0xA0. The status flag and the enable bit sit at offsets of the block's own choosing, and all three offsets are parameters.

Top module: `drop_ctr_top`

## Requirements
- R1: After reset the tally is zero, the status flag is 0, the enable bit is 0 and the interrupt output is low.
- R2: Each cycle with `drop_pulse` high and no tally read raises the tally by exactly one at the next clock edge.
- R3: While `host_rd` is high with `host_addr` equal to 0xA0, `host_rdata` shows the tally zero-extended in the same cycle, and the tally is zero after that clock edge.
- R4: When a tally read and a drop pulse fall in the same cycle, the read returns the value before the increment and the tally becomes 1.
- R5: A drop pulse that moves the tally from its half-way-minus-one value (0x7FFFFFFF at 32 bits) to its half-way value sets the status flag at that clock edge.
- R6: A drop pulse at the all-ones tally wraps the tally to zero and does not set the status flag.
- R7: The status flag is bit 0 at offset 0xB8. Writing `host_wbit`=1 to offset 0xB8 clears it, and writing 0 leaves it unchanged. The flag stays set until it is cleared, and a crossing in the same cycle as a clear leaves it set.
- R8: The enable bit is bit 0 at offset 0xBC. A write stores `host_wbit` in it. `irq_out` is high exactly when both the status flag and the enable bit are 1.
- R9: Reads and writes at any offset other than 0xA0 leave the tally unchanged, and a write to 0xA0 also leaves it unchanged. A read of an unmapped offset returns zero. `host_rdata` is zero whenever `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drop_pulse | input | 1 | One-cycle pulse for each discarded frame |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W (8) | Byte offset of the register being accessed |
| host_wbit | input | 1 | Write data bit (bit 0 of the written word) |
| host_rdata | output | DATA_W (32) | Read data, valid in the cycle the read strobe is high |
| irq_stat | output | 1 | Sticky midpoint-crossing flag |
| irq_out | output | 1 | Interrupt request: flag AND enable |

## Verification
A tally that is wrong by even one count shows up at the next read of offset 0xA0. A clear that fails to happen on a read shows up as an inflated value at the following read, one access later. A midpoint detector that fires early, fires late or fires at the wrap flips `irq_stat` in the cycle right after the offending pulse. The bench therefore runs a narrow-width copy next to the full-width one, so that both the crossing and the wrap can be reached. A stuck or leaky status flag, or a wrong enable path, shows as a mismatch on `irq_out` at the next sample, since `irq_out` is compared on every cycle.

// File: rtl/drc_pkg.sv
package drc_pkg;
   // Which register the current host access targets
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CNT  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_ENA  = 2'd3
   } drc_sel_e;
endpackage

// File: rtl/drc_regdec.sv
module drc_regdec
   import drc_pkg::*;
#(
   parameter int unsigned          ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]    CNT_OFS  = 'hA0,
   parameter logic [ADDR_W-1:0]    STAT_OFS = 'hB8,
   parameter logic [ADDR_W-1:0]    ENA_OFS  = 'hBC
) (
   input  logic [ADDR_W-1:0] addr,
   output drc_sel_e          sel
);
   // Elaboration checks: offsets must be distinct
   if (CNT_OFS == STAT_OFS || CNT_OFS == ENA_OFS || STAT_OFS == ENA_OFS) begin : g_bad_ofs
      $error("drc_regdec: register offsets must differ");
   end

   always_comb begin
      if (addr == CNT_OFS)       sel = SEL_CNT;
      else if (addr == STAT_OFS) sel = SEL_STAT;
      else if (addr == ENA_OFS)  sel = SEL_ENA;
      else                       sel = SEL_NONE;
   end
endmodule

// File: rtl/drc_counter.sv
module drc_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             mid_evt
);
   localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};
   localparam logic [CNT_W-1:0] ALL_ONE = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 2) begin : g_bad_w
      $error("drc_counter: CNT_W must be at least 2");
   end

   // Crossing into the upper half, only on a real increment
   assign mid_evt = inc && !clr && (cnt == HALF_M1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= inc ? ONE : '0;
      else if (inc)    cnt <= cnt + ONE;
   end

   assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (cnt == $past(cnt) + ONE));
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !inc) |=> (cnt == '0));
   assert_coincide_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && inc) |=> (cnt == ONE));
   assert_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mid_evt |=> (cnt[CNT_W-1] && !$past(cnt[CNT_W-1])));
   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt == ALL_ONE) |=> (cnt == '0 && !$past(mid_evt)));
endmodule

// File: rtl/drc_irq_flag.sv
module drc_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_req,
   input  logic en_wr,
   input  logic en_val,
   output logic status,
   output logic enable,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       status <= 1'b0;
      else if (set_evt) status <= 1'b1;
      else if (clr_req) status <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     enable <= 1'b0;
      else if (en_wr) enable <= en_val;
   end

   assign irq = status & enable;

   assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> status);
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !clr_req) |=> status);
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_evt) |=> !status);
   assert_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(enable));
endmodule

// File: rtl/drop_ctr_top.sv
module drop_ctr_top
   import drc_pkg::*;
#(
   parameter int unsigned          DATA_W   = 32,
   parameter int unsigned          CNT_W    = 32,
   parameter int unsigned          ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]    CNT_OFS  = 'hA0,
   parameter logic [ADDR_W-1:0]    STAT_OFS = 'hB8,
   parameter logic [ADDR_W-1:0]    ENA_OFS  = 'hBC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drop_pulse,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wbit,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq_stat,
   output logic              irq_out
);
   if (CNT_W > DATA_W) begin : g_bad_fit
      $error("drop_ctr_top: CNT_W must not exceed DATA_W");
   end

   drc_sel_e          sel;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] cnt_ext;
   logic              mid_evt;
   logic              rd_clr;
   logic              enable;

   drc_regdec #(
      .ADDR_W(ADDR_W), .CNT_OFS(CNT_OFS), .STAT_OFS(STAT_OFS), .ENA_OFS(ENA_OFS)
   ) u_dec (
      .addr(host_addr),
      .sel (sel)
   );

   assign rd_clr = host_rd && (sel == SEL_CNT);

   drc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (drop_pulse),
      .clr    (rd_clr),
      .cnt    (cnt),
      .mid_evt(mid_evt)
   );

   drc_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_evt(mid_evt),
      .clr_req(host_wr && (sel == SEL_STAT) && host_wbit),
      .en_wr  (host_wr && (sel == SEL_ENA)),
      .en_val (host_wbit),
      .status (irq_stat),
      .enable (enable),
      .irq    (irq_out)
   );

   // Width variant: pass through or zero-extend the tally
   if (CNT_W == DATA_W) begin : g_full
      assign cnt_ext = cnt;
   end else begin : g_pad
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt};
   end

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         case (sel)
            SEL_CNT:  host_rdata = cnt_ext;
            SEL_STAT: host_rdata = {{(DATA_W-1){1'b0}}, irq_stat};
            SEL_ENA:  host_rdata = {{(DATA_W-1){1'b0}}, enable};
            default:  host_rdata = '0;
         endcase
      end
   end

   assert_other_ofs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!drop_pulse && !rd_clr) |=> $stable(cnt));
   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> irq_stat);
endmodule

// File: tb/tb_drop_ctr_top.sv
module tb_drop_ctr_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        drop_pulse = 1'b0;
   logic        host_rd = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_addr = 8'h00;
   logic        host_wbit = 1'b0;
   logic [31:0] rd32, rd8;
   logic        st_o32, irq_o32, st_o8, irq_o8;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;

   // Bench model
   logic [31:0] m32 = '0;
   logic [7:0]  m8  = '0;
   logic        st32 = 1'b0, st8 = 1'b0, en = 1'b0;

   always #4 clk = ~clk;

   drop_ctr_top dut (
      .clk(clk), .rst_n(rst_n), .drop_pulse(drop_pulse), .host_rd(host_rd),
      .host_wr(host_wr), .host_addr(host_addr), .host_wbit(host_wbit),
      .host_rdata(rd32), .irq_stat(st_o32), .irq_out(irq_o32)
   );

   drop_ctr_top #(.CNT_W(8)) dut_small (
      .clk(clk), .rst_n(rst_n), .drop_pulse(drop_pulse), .host_rd(host_rd),
      .host_wr(host_wr), .host_addr(host_addr), .host_wbit(host_wbit),
      .host_rdata(rd8), .irq_stat(st_o8), .irq_out(irq_o8)
   );

   function automatic logic [31:0] exp_rd(input logic [31:0] c, input logic s,
                                          input logic e, input logic [7:0] a);
      case (a)
         8'hA0:   return c;
         8'hB8:   return {31'b0, s};
         8'hBC:   return {31'b0, e};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_for(input logic [7:0] a, input logic d);
      if (a == 8'hA0) return d ? "R4" : "R3";
      if (a == 8'hB8) return "R7";
      if (a == 8'hBC) return "R8";
      return "R9";
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic d, input logic r, input logic w,
                       input logic [7:0] a, input logic b);
      logic clr, e8, e32;
      @(negedge clk);
      check("R8 irq32", {31'b0, irq_o32}, {31'b0, st32 & en});
      check("R8 irq8",  {31'b0, irq_o8},  {31'b0, st8 & en});
      check("R7 stat8", {31'b0, st_o8},   {31'b0, st8});
      drop_pulse = d; host_rd = r; host_wr = w; host_addr = a; host_wbit = b;
      #1;
      if (r) begin
         check(tag_for(a, d), rd32, exp_rd(m32, st32, en, a));
         check(tag_for(a, d), rd8,  exp_rd({24'b0, m8}, st8, en, a));
      end else begin
         check("R9 idle rdata", rd32, 32'h0);
      end
      @(posedge clk);
      clr = r && (a == 8'hA0);
      e8  = d && !clr && (m8 == 8'h7F);
      e32 = d && !clr && (m32 == 32'h7FFF_FFFF);
      m8  = clr ? {7'b0, d} : (d ? m8 + 8'd1 : m8);
      m32 = clr ? {31'b0, d} : (d ? m32 + 32'd1 : m32);
      if (e8) st8 = 1'b1; else if (w && a == 8'hB8 && b) st8 = 1'b0;
      if (e32) st32 = 1'b1; else if (w && a == 8'hB8 && b) st32 = 1'b0;
      if (w && a == 8'hBC) en = b;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h0D0F_5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      @(negedge clk);
      check("R1 irq", {30'b0, irq_o32, st_o32}, 32'h0);
      step(0, 1, 0, 8'hA0, 0);
      step(0, 1, 0, 8'hBC, 0);
      // R2: plain increments then read
      for (int i = 0; i < 5; i++) step(1, 0, 0, 8'h00, 0);
      step(0, 1, 0, 8'hA0, 0);
      step(0, 1, 0, 8'hA0, 0);
      check("R2 count after 5", m32, 32'h0);
      // R4: coincident read and drop
      step(1, 0, 0, 8'h00, 0);
      step(1, 1, 0, 8'hA0, 0);
      step(0, 1, 0, 8'hA0, 0);
      // R9: writes to tally and other offsets ignored
      step(1, 0, 0, 8'h00, 0);
      step(0, 0, 1, 8'hA0, 1);
      step(0, 1, 0, 8'h44, 0);
      step(0, 0, 1, 8'h44, 1);
      step(0, 1, 0, 8'hA0, 0);
      // R5: reach midpoint on the narrow copy, enable on
      step(0, 0, 1, 8'hBC, 1);
      for (int i = 0; i < 127; i++) step(1, 0, 0, 8'h00, 0);
      step(0, 1, 0, 8'hB8, 0);
      step(1, 0, 0, 8'h00, 0);
      step(0, 1, 0, 8'hB8, 0);
      // R7: write 0 keeps flag, write 1 clears
      step(0, 0, 1, 8'hB8, 0);
      step(0, 1, 0, 8'hB8, 0);
      step(0, 0, 1, 8'hB8, 1);
      step(0, 1, 0, 8'hB8, 0);
      // R6: wrap 255 -> 0 without setting the flag
      for (int i = 0; i < 128; i++) step(1, 0, 0, 8'h00, 0);
      step(0, 1, 0, 8'hB8, 0);
      check("R6 wrap count", {24'b0, m8}, 32'h0);
      // R7: crossing in same cycle as clear keeps flag set
      for (int i = 0; i < 127; i++) step(1, 0, 0, 8'h00, 0);
      step(1, 0, 1, 8'hB8, 1);
      step(0, 1, 0, 8'hB8, 0);
      // R8: enable off masks irq
      step(0, 0, 1, 8'hBC, 0);
      step(0, 1, 0, 8'hBC, 0);
      step(0, 0, 1, 8'hBC, 1);
      // Constrained random mix
      for (int i = 0; i < 4000; i++) begin
         logic d, r, w, b;
         logic [7:0] a;
         int unsigned k;
         d = ($urandom % 100) < 60;
         r = ($urandom % 100) < 8;
         w = !r && (($urandom % 100) < 5);
         b = $urandom % 2;
         k = $urandom % 4;
         a = (k == 0) ? 8'hA0 : (k == 1) ? 8'hB8 : (k == 2) ? 8'hBC : 8'($urandom);
         step(d, r, w, a, b);
      end
      step(0, 1, 0, 8'hA0, 0);
      step(0, 0, 0, 8'h00, 0);
      finish_run();
   end
endmodule